// File: doc/BRIEF.md
# Idle and Power-Down Mode Controller

This block holds the power-control register of an 8-bit controller and runs the low-power mode state machine. Software writes the register through a byte-wide special-function-register write port. In idle, the block stops the processor clock while the timers, serial logic and interrupt logic keep their clock. In power-down, it stops every clock. Register contents are kept in both modes.

The block also tells the pad ring what to do with the address-latch and program-store strobes. It reports whether the low address/data port must float, and whether the high port must keep showing the fetch address. Both depend on the current mode and on whether code is fetched from external program memory.

Idle ends when any enabled interrupt is pending, and hardware clears the idle bit when that happens. Power-down ends only through a hardware reset. That reset request is filtered: it must be held for a parameterised number of clock edges before it acts.

Top module: `pwr_mode_top`

## Requirements
- R1: While `rst_n` is low, the block is in run mode with both clock enables at 1, `dblBaud` at 0, `genFlags` at 0, and `strobeOvr`, `strobeLvl`, `loPortFloat` and `hiPortAddr` all at 0.
- R2: A write with `sfrWe`=1 and `sfrAddr` equal to `PCON_ADDR` (default 0x87), made in run mode, loads data bit 7 into `dblBaud` and data bits 3:2 into `genFlags[1:0]` at the sampling edge. A write to any other address changes nothing.
- R3: In that write, data bit 1 set enters power-down, and data bit 0 set alone enters idle. If both bits are set, power-down is entered. The clock enables take the new mode at the same edge that samples the write, and they are driven straight from flops.
- R4: In idle, `cpuClkEn`=0 and `perClkEn`=1.
- R5: In idle, `irqPending`=1 at an edge returns the block to run mode at that edge and clears the idle bit. The flag bits and the baud bit are kept. In run mode, `irqPending` has no effect.
- R6: In power-down, both clock enables are 0. `irqPending` and register writes have no effect there.
- R7: The strobe override is coded as follows. `strobeOvr`=0 in run mode. `strobeOvr`=1 with `strobeLvl`=1 (strobes forced high) in idle. `strobeOvr`=1 with `strobeLvl`=0 (strobes forced low) in power-down.
- R8: `loPortFloat` is 1 when `extFetch`=1 and the block is in idle or power-down. `hiPortAddr` is 1 only when `extFetch`=1 and the block is in idle.
- R9: `rstPin` takes effect only after it has been high at `RST_HOLD` consecutive edges (default 24). At that edge the register clears and the block returns to run mode from any mode. A shorter pulse has no effect.
- R10: Register writes made while the block is in idle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running block clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| rstPin | input | 1 | Hardware reset request, must be held to act |
| sfrWe | input | 1 | Register write strobe |
| sfrAddr | input | 8 | Register write address |
| sfrWdata | input | 8 | Register write data |
| irqPending | input | 1 | An enabled interrupt is pending |
| extFetch | input | 1 | Code is fetched from external program memory |
| cpuClkEn | output | 1 | Processor clock enable |
| perClkEn | output | 1 | Peripheral clock enable |
| dblBaud | output | 1 | Serial baud doubling bit |
| genFlags | output | 2 | General-purpose software flags |
| strobeOvr | output | 1 | Strobe pins are overridden |
| strobeLvl | output | 1 | Level forced on the strobe pins |
| loPortFloat | output | 1 | Low address/data port must float |
| hiPortAddr | output | 1 | High port keeps driving the address |

## Verification
The assertions assume that `irqPending` already reflects only enabled interrupts. They also assume that the reset request is an ordinary synchronous level, so any gap in `rstPin` restarts the hold count.

The stimulus keeps to these assumptions. It changes every input once per cycle, just after the active edge. It drives reset pulses both one edge short of the hold time and exactly at the hold time. It combines an idle write with a pending interrupt in the same cycle, and it exercises writes and interrupts while the block is in power-down.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_IDLE = 2'd1,
    MODE_DOWN = 2'd2
  } modeE;

  // strobes from the control FSM into the register datapath
  typedef struct packed {
    logic wrAccept;  // load the register from the write data
    logic clrIdle;   // interrupt wake: drop the idle bit
    logic clrAll;    // filtered hardware reset
  } pconStrobeT;

  localparam int BitIdle = 0;
  localparam int BitDown = 1;
  localparam int BitGf0  = 2;
  localparam int BitGf1  = 3;
  localparam int BitDbl  = 7;

endpackage

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter logic [7:0]  PCON_ADDR = 8'h87,
  parameter int          RST_HOLD  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rstPin,
  input  logic              sfrWe,
  input  logic [ADDR_W-1:0] sfrAddr,
  input  logic              wrDown,
  input  logic              wrIdle,
  input  logic              irqPending,
  output pconStrobeT        strobe,
  output logic              cpuClkEn,
  output logic              perClkEn,
  output logic              strobeOvr,
  output logic              strobeLvl
);

  localparam int               CNT_W   = $clog2(RST_HOLD + 1);
  localparam logic [CNT_W-1:0] FIRE_AT = CNT_W'(RST_HOLD - 1);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(RST_HOLD);

  modeE             modeQ, modeNext;
  logic [CNT_W-1:0] rstCnt;
  logic             rstFire;
  logic             addrHit;
  logic             cpuEnQ, perEnQ, ovrQ, lvlQ;

  assign addrHit = sfrWe && (sfrAddr == PCON_ADDR[ADDR_W-1:0]);
  assign rstFire = rstPin && (rstCnt >= FIRE_AT);

  // reset hold filter: counts consecutive sampled-high edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                rstCnt <= '0;
    else if (!rstPin)          rstCnt <= '0;
    else if (rstCnt != CNT_SAT) rstCnt <= rstCnt + 1'b1;
  end

  always_comb begin
    strobe   = '0;
    modeNext = modeQ;
    if (rstFire) begin
      strobe.clrAll = 1'b1;
      modeNext      = MODE_RUN;
    end else begin
      case (modeQ)
        MODE_RUN: begin
          if (addrHit) begin
            strobe.wrAccept = 1'b1;
            if (wrDown)      modeNext = MODE_DOWN;
            else if (wrIdle) modeNext = MODE_IDLE;
          end
        end
        MODE_IDLE: begin
          if (irqPending) begin
            strobe.clrIdle = 1'b1;
            modeNext       = MODE_RUN;
          end
        end
        default: modeNext = modeQ;
      endcase
    end
  end

  // enables are flops fed from the next mode: one edge, no decode glitch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      modeQ  <= MODE_RUN;
      cpuEnQ <= 1'b1;
      perEnQ <= 1'b1;
      ovrQ   <= 1'b0;
      lvlQ   <= 1'b0;
    end else begin
      modeQ  <= modeNext;
      cpuEnQ <= (modeNext == MODE_RUN);
      perEnQ <= (modeNext != MODE_DOWN);
      ovrQ   <= (modeNext != MODE_RUN);
      lvlQ   <= (modeNext == MODE_IDLE);
    end
  end

  assign cpuClkEn  = cpuEnQ;
  assign perClkEn  = perEnQ;
  assign strobeOvr = ovrQ;
  assign strobeLvl = lvlQ;

  AST_EN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    !perEnQ |-> !cpuEnQ); // R4
  AST_IDLE_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (modeQ == MODE_IDLE && irqPending && !rstPin) |=> cpuEnQ); // R5
  AST_DOWN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (modeQ == MODE_DOWN && !rstPin) |=> (modeQ == MODE_DOWN && !perEnQ)); // R6
  AST_SHORT_RST: assert property (@(posedge clk) disable iff (!rst_n)
    (modeQ == MODE_DOWN && rstPin && rstCnt < FIRE_AT) |=> modeQ == MODE_DOWN); // R9
  AST_STROBE_LVL: assert property (@(posedge clk) disable iff (!rst_n)
    lvlQ |-> (ovrQ && perEnQ)); // R7

endmodule

// File: rtl/pwr_reg_dp.sv
module pwr_reg_dp
  import pwr_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  pconStrobeT strobe,
  input  logic [7:0] sfrWdata,
  input  logic       extFetch,
  output logic       dblBaud,
  output logic [1:0] genFlags,
  output logic       downBit,
  output logic       idleBit,
  output logic       loPortFloat,
  output logic       hiPortAddr
);

  localparam logic [7:0] KEEP_MASK = 8'b1000_1110;

  logic [7:0] pconQ, wrVal;

  // unused bits 6:4 are held at zero; down wins over idle
  always_comb begin
    wrVal         = sfrWdata & KEEP_MASK;
    wrVal[BitIdle] = sfrWdata[BitIdle] & ~sfrWdata[BitDown];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pconQ <= '0;
    else if (strobe.clrAll)    pconQ <= '0;
    else if (strobe.wrAccept)  pconQ <= wrVal;
    else if (strobe.clrIdle)   pconQ[BitIdle] <= 1'b0;
  end

  assign dblBaud     = pconQ[BitDbl];
  assign genFlags    = {pconQ[BitGf1], pconQ[BitGf0]};
  assign downBit     = pconQ[BitDown];
  assign idleBit     = pconQ[BitIdle];
  assign loPortFloat = extFetch & (pconQ[BitDown] | pconQ[BitIdle]);
  assign hiPortAddr  = extFetch & pconQ[BitIdle];

  AST_DOWN_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.wrAccept && sfrWdata[BitDown] && !strobe.clrAll) |=> (downBit && !idleBit)); // R3
  AST_WAKE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.clrIdle |=> (!idleBit && $stable(genFlags) && $stable(dblBaud))); // R5
  AST_ONE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    !(downBit && idleBit)); // R3
  AST_RST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.clrAll |=> (pconQ == 8'h00)); // R9

endmodule

// File: rtl/pwr_mode_top.sv
module pwr_mode_top
  import pwr_mode_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter logic [7:0]  PCON_ADDR = 8'h87,
  parameter int          RST_HOLD  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rstPin,
  input  logic              sfrWe,
  input  logic [ADDR_W-1:0] sfrAddr,
  input  logic [7:0]        sfrWdata,
  input  logic              irqPending,
  input  logic              extFetch,
  output logic              cpuClkEn,
  output logic              perClkEn,
  output logic              dblBaud,
  output logic [1:0]        genFlags,
  output logic              strobeOvr,
  output logic              strobeLvl,
  output logic              loPortFloat,
  output logic              hiPortAddr
);

  pconStrobeT strobe;
  logic       downBit, idleBit;

  pwr_mode_ctrl #(
    .ADDR_W(ADDR_W), .PCON_ADDR(PCON_ADDR), .RST_HOLD(RST_HOLD)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .rstPin(rstPin),
    .sfrWe(sfrWe), .sfrAddr(sfrAddr),
    .wrDown(sfrWdata[BitDown]), .wrIdle(sfrWdata[BitIdle]),
    .irqPending(irqPending), .strobe(strobe),
    .cpuClkEn(cpuClkEn), .perClkEn(perClkEn),
    .strobeOvr(strobeOvr), .strobeLvl(strobeLvl)
  );

  pwr_reg_dp dp_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .sfrWdata(sfrWdata),
    .extFetch(extFetch), .dblBaud(dblBaud), .genFlags(genFlags),
    .downBit(downBit), .idleBit(idleBit),
    .loPortFloat(loPortFloat), .hiPortAddr(hiPortAddr)
  );

  // register mode bits and clock enables come from separate flops
  AST_BITS_MATCH_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (downBit == !perClkEn) && (idleBit == (perClkEn && !cpuClkEn))); // R6

endmodule

// File: tb/pwr_mode_top_tb.sv
module pwr_mode_top_tb_top;

  localparam int HOLD = 24;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rstPin = 1'b0, sfrWe = 1'b0, irqPending = 1'b0, extFetch = 1'b0;
  logic [7:0] sfrAddr = 8'h00, sfrWdata = 8'h00;
  logic       cpuClkEn, perClkEn, dblBaud, strobeOvr, strobeLvl, loPortFloat, hiPortAddr;
  logic [1:0] genFlags;

  int    checks = 0;
  int    errors = 0;
  string phase = "R1";
  bit    done = 1'b0;

  always #2.5 clk = ~clk;

  pwr_mode_top dut_i (
    .clk(clk), .rst_n(rst_n), .rstPin(rstPin), .sfrWe(sfrWe), .sfrAddr(sfrAddr),
    .sfrWdata(sfrWdata), .irqPending(irqPending), .extFetch(extFetch),
    .cpuClkEn(cpuClkEn), .perClkEn(perClkEn), .dblBaud(dblBaud), .genFlags(genFlags),
    .strobeOvr(strobeOvr), .strobeLvl(strobeLvl),
    .loPortFloat(loPortFloat), .hiPortAddr(hiPortAddr)
  );

  // behavioural reference: mode 0 run, 1 idle, 2 down
  int       mMode = 0;
  int       mCnt = 0;
  bit       mDbl = 0;
  bit [1:0] mGf = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mMode = 0; mCnt = 0; mDbl = 0; mGf = 0;
    end else begin
      bit fire;
      fire = rstPin && (mCnt + 1 >= HOLD);
      mCnt = rstPin ? ((mCnt < HOLD) ? mCnt + 1 : HOLD) : 0;
      if (fire) begin
        mMode = 0; mDbl = 0; mGf = 0;                       // R9
      end else if (mMode == 0 && sfrWe && sfrAddr == 8'h87) begin
        mDbl = sfrWdata[7]; mGf = sfrWdata[3:2];            // R2
        if (sfrWdata[1])      mMode = 2;                    // R3
        else if (sfrWdata[0]) mMode = 1;
      end else if (mMode == 1 && irqPending) begin
        mMode = 0;                                          // R5
      end
    end
  end

  task automatic check(input string req, input string name, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s (%s) %s act=%0h exp=%0h t=%0t", req, phase, name, act, exp, $time);
    end
  endtask

  // compare every output on every falling edge
  always @(negedge clk) begin
    if (!done) begin
      check("R4", "cpuClkEn", cpuClkEn, mMode == 0);
      check("R6", "perClkEn", perClkEn, mMode != 2);
      check("R2", "dblBaud",  dblBaud, mDbl);
      check("R2", "genFlags", genFlags, mGf);
      check("R7", "strobeOvr", strobeOvr, mMode != 0);
      check("R7", "strobeLvl", strobeLvl, mMode == 1);
      check("R8", "loPortFloat", loPortFloat, (mMode != 0) && extFetch);
      check("R8", "hiPortAddr", hiPortAddr, (mMode == 1) && extFetch);
    end
  end

  task automatic step(input bit we, input logic [7:0] a, input logic [7:0] d,
                      input bit irq, input bit rp, input bit ext);
    sfrWe = we; sfrAddr = a; sfrWdata = d; irqPending = irq; rstPin = rp; extFetch = ext;
    @(posedge clk); #1;
  endtask

  task automatic idleFor(input int n, input bit irq, input bit rp, input bit ext);
    for (int i = 0; i < n; i++) step(1'b0, 8'h00, 8'h00, irq, rp, ext);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    phase = "R1";                               // reset state
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idleFor(2, 0, 0, 1);

    phase = "R2";                               // load baud and flags, other address ignored
    step(1, 8'h87, 8'h8C, 0, 0, 0);
    step(1, 8'h86, 8'h03, 0, 0, 0);
    idleFor(2, 0, 0, 0);

    phase = "R5";                               // interrupt in run has no effect
    idleFor(2, 1, 0, 0);

    phase = "R4";                               // enter idle, external fetch
    step(1, 8'h87, 8'h05, 0, 0, 1);
    idleFor(3, 0, 0, 1);
    phase = "R10";                              // write while idle ignored
    step(1, 8'h87, 8'hFE, 0, 0, 1);
    idleFor(2, 0, 0, 0);
    phase = "R5";                               // wake keeps flags
    step(0, 8'h00, 8'h00, 1, 0, 1);
    idleFor(2, 0, 0, 1);

    phase = "R3";                               // both mode bits: down wins
    step(1, 8'h87, 8'h4B, 0, 0, 1);
    idleFor(2, 0, 0, 1);
    phase = "R6";                               // down ignores irq and writes
    idleFor(3, 1, 0, 0);
    step(1, 8'h87, 8'h00, 0, 0, 1);
    phase = "R9";                               // short pulse then full hold
    idleFor(HOLD - 1, 0, 1, 1);
    idleFor(2, 0, 0, 1);
    idleFor(HOLD, 0, 1, 0);
    idleFor(3, 0, 0, 0);

    phase = "R9";                               // filtered reset exits idle
    step(1, 8'h87, 8'h09, 0, 0, 0);
    idleFor(HOLD + 2, 0, 1, 0);
    idleFor(2, 0, 0, 0);

    phase = "R3";                               // idle write with irq already pending
    step(1, 8'h87, 8'h01, 1, 0, 1);
    idleFor(3, 1, 0, 1);
    step(1, 8'h87, 8'h02, 0, 0, 0);
    idleFor(2, 0, 0, 0);

    phase = "R1";                               // power-on reset from down
    rst_n = 1'b0;
    idleFor(2, 0, 0, 1);
    rst_n = 1'b1;
    idleFor(2, 0, 0, 0);

    finishRun();
  end

endmodule